// File: doc/BRIEF.md
# Multiplexed Bus Latch and Region Decoder

This block sits on the slave side of an 8-bit processor bus where one set of eight pins carries the low address byte during the strobe phase and data afterwards. A dedicated port carries the high address byte. On each clock edge where the address strobe is high, the block captures the shared pins into a low-address register. It joins that byte with the live high byte to form a 16-bit address, and it publishes that address for the attached memories.

The address is decoded into five chip selects. Two are single-address I/O ports: an input port at 0x5000 and an output port at 0x5001. The other three are memory windows. A 1K window covers 0x4000–0x43FF. A 20K window covers 0x0000–0x4FFF, which is not a power of two in size. A 32K window covers 0x2000–0x9FFF, whose start is not a multiple of its size. Each window is written as a small set of don't-care cubes that are ORed together. The windows overlap, so a fixed priority resolves each address to at most one select.

The direction line turns each select into a read enable or a write enable. While a read is under way, the block drives the selected device's read byte onto the shared pins. At all other times it leaves those pins released. The pins map onto a processor bus, so there is no valid/ready handshake: every pin is a plain level.

Top module: `mbus_decode`

## Requirements
- R1: On a rising clock edge with `as_i` = 1, the low address register takes the value on `ad_io`. With `as_i` = 0 it holds its value. A synchronous `rst` = 1 clears it to 0x00.
- R2: `addr_o[15:8]` always equals `addr_hi_i`, and `addr_o[7:0]` is the low address register.
- R3: Select bit 2 (1K RAM) is active for addresses 0x4000–0x43FF, which match the top six bits 010000.
- R4: Select bit 3 (20K RAM) covers 0x0000–0x4FFF, which is top bits 00 or top four bits 0100, except where a higher-priority region wins.
- R5: Select bit 4 (32K RAM) covers 0x2000–0x9FFF, which is top bits 001, 01 or 100, except where a higher-priority region wins.
- R6: Select bit 0 (input port) is active only at exactly 0x5000. Select bit 1 (output port) is active only at exactly 0x5001.
- R7: Priority, from highest to lowest, is bit 0, bit 1, bit 2, bit 3, bit 4. At most one select is active. Addresses 0xA000–0xFFFF activate no select.
- R8: For each region, `rd_en_o` = select AND `rw_i`, and `wr_en_o` = select AND NOT `rw_i`. The value `rw_i` = 1 means read.
- R9: `ad_oe_o` is 1 exactly when a read enable is active and `as_i` = 0. While it is 1, `ad_io` carries the selected region's byte from `rdata_i` (region k uses bits 8k+7:8k). Otherwise `ad_io` is released.
- R10: `wdata_o` always mirrors the value present on `ad_io`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| as_i | input | 1 | Address strobe; shared pins hold the low address |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| addr_hi_i | input | 8 | High address byte |
| ad_io | inout | 8 | Shared low-address / data pins |
| rdata_i | input | 40 | Read bytes of the five regions, region k at bits 8k+7:8k |
| addr_o | output | 16 | Full demultiplexed address |
| sel_o | output | 5 | One-hot-or-zero chip selects |
| rd_en_o | output | 5 | Per-region read enables |
| wr_en_o | output | 5 | Per-region write enables |
| wdata_o | output | 8 | Write data seen on the shared pins |
| ad_oe_o | output | 1 | Block is driving the shared pins |

## Verification
Directed addresses are placed on both sides of every region edge: 0x1FFF/0x2000, 0x3FFF/0x4000, 0x43FF/0x4400, 0x4FFF/0x5000/0x5001/0x5002, and 0x9FFF/0xA000, plus 0xFFFF. These separate a wrong cube bit from a wrong priority. Random addresses with a random direction follow, compared against a range-based reference. That reference shares nothing with the cube form, so a missing term in a non-power-of-two or unaligned window shows up. The latch is tried with changing pin values while the strobe is low, and with a reset after a capture. The drive enable is checked with the strobe still high during a read, which separates the strobe gating from the select logic.

// File: rtl/mbus_decode_pkg.sv
package mbus_decode_pkg;
  localparam int AW      = 16;
  localparam int NREG    = 5;
  localparam int MAXCUBE = 3;

  localparam int RG_IN   = 0;
  localparam int RG_OUT  = 1;
  localparam int RG_R1K  = 2;
  localparam int RG_R20K = 3;
  localparam int RG_R32K = 4;

  typedef struct packed {
    logic          used;
    logic [AW-1:0] care;
    logic [AW-1:0] val;
  } cube_t;

  function automatic cube_t mk(logic [AW-1:0] care, logic [AW-1:0] val);
    cube_t c;
    c.used = 1'b1;
    c.care = care;
    c.val  = val;
    return c;
  endfunction

  // Region r, term t: cubes that are ORed to form the raw match of a region.
  function automatic cube_t region_cube(int r, int t);
    cube_t none;
    none = '0;
    case (r)
      RG_IN:   if (t == 0) return mk(16'hFFFF, 16'h5000);
      RG_OUT:  if (t == 0) return mk(16'hFFFF, 16'h5001);
      RG_R1K:  if (t == 0) return mk(16'hFC00, 16'h4000);
      RG_R20K: begin
        if (t == 0) return mk(16'hC000, 16'h0000);
        if (t == 1) return mk(16'hF000, 16'h4000);
      end
      RG_R32K: begin
        if (t == 0) return mk(16'hE000, 16'h2000);
        if (t == 1) return mk(16'hC000, 16'h4000);
        if (t == 2) return mk(16'hE000, 16'h8000);
      end
      default: return none;
    endcase
    return none;
  endfunction
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] pins,
  output logic [DW-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst)         lo_q <= '0;
    else if (strobe) lo_q <= pins;
  end
endmodule

// File: rtl/mbus_region_decode.sv
module mbus_region_decode
  import mbus_decode_pkg::*;
#(
  parameter int N = NREG,
  parameter int T = MAXCUBE
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  raw,
  output logic [N-1:0]  sel
);
  logic [T-1:0] hit [N];

  for (genvar r = 0; r < N; r++) begin : g_reg
    for (genvar t = 0; t < T; t++) begin : g_term
      localparam cube_t CB = region_cube(r, t);
      assign hit[r][t] = CB.used && ((addr & CB.care) == CB.val);
    end
    assign raw[r] = |hit[r];
  end

  // Fixed priority: lower index wins.
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel   = '0;
    for (int r = 0; r < N; r++) begin
      if (raw[r] && !taken) begin
        sel[r] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbus_enable_gen.sv
module mbus_enable_gen #(
  parameter int N  = 5,
  parameter int DW = 8
) (
  input  logic [N-1:0]    sel,
  input  logic            rw,
  input  logic            strobe,
  input  logic [N*DW-1:0] rdata,
  output logic [N-1:0]    rd_en,
  output logic [N-1:0]    wr_en,
  output logic            oe,
  output logic [DW-1:0]   dout
);
  assign rd_en = sel & {N{rw}};
  assign wr_en = sel & {N{~rw}};
  assign oe    = (|rd_en) && !strobe;

  always_comb begin
    dout = '0;
    for (int k = 0; k < N; k++)
      if (rd_en[k]) dout = dout | rdata[k*DW +: DW];
  end
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_decode_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               as_i,
  input  logic               rw_i,
  input  logic [DW-1:0]      addr_hi_i,
  inout  wire  [DW-1:0]      ad_io,
  input  logic [NREG*DW-1:0] rdata_i,
  output logic [AW-1:0]      addr_o,
  output logic [NREG-1:0]    sel_o,
  output logic [NREG-1:0]    rd_en_o,
  output logic [NREG-1:0]    wr_en_o,
  output logic [DW-1:0]      wdata_o,
  output logic               ad_oe_o
);
  logic [DW-1:0]   lo_q;
  logic [NREG-1:0] raw;
  logic [DW-1:0]   dout;

  mbus_addr_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst(rst), .strobe(as_i), .pins(ad_io), .lo_q(lo_q)
  );

  assign addr_o = {addr_hi_i, lo_q};

  mbus_region_decode #(.N(NREG), .T(MAXCUBE)) u_dec (
    .addr(addr_o), .raw(raw), .sel(sel_o)
  );

  mbus_enable_gen #(.N(NREG), .DW(DW)) u_en (
    .sel(sel_o), .rw(rw_i), .strobe(as_i), .rdata(rdata_i),
    .rd_en(rd_en_o), .wr_en(wr_en_o), .oe(ad_oe_o), .dout(dout)
  );

  assign ad_io   = ad_oe_o ? dout : {DW{1'bz}};
  assign wdata_o = ad_io;
endmodule

// File: rtl/mbus_decode_chk.sv
module mbus_decode_chk
  import mbus_decode_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            as_i,
  input logic            rw_i,
  input logic [7:0]      addr_hi_i,
  input logic [7:0]      ad_io,
  input logic [AW-1:0]   addr_o,
  input logic [NREG-1:0] sel_o,
  input logic [NREG-1:0] rd_en_o,
  input logic [NREG-1:0] wr_en_o,
  input logic            ad_oe_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sel_o)); // R7
  AST_HIGH_NONE: assert property (@(posedge clk) disable iff (rst) (addr_o >= 16'hA000) |-> (sel_o == '0)); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) !as_i |=> $stable(addr_o[7:0])); // R1
  AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (rst) as_i |=> (addr_o[7:0] == $past(ad_io))); // R1
  AST_HI_PASS: assert property (@(posedge clk) disable iff (rst) addr_o[15:8] == addr_hi_i); // R2
  AST_EN_COVER: assert property (@(posedge clk) disable iff (rst) (rd_en_o | wr_en_o) == sel_o); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) (rd_en_o & wr_en_o) == '0); // R8
  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst) ad_oe_o |-> (rw_i && !as_i && (sel_o != '0))); // R9
endmodule

bind mbus_decode mbus_decode_chk u_chk (
  .clk(clk), .rst(rst), .as_i(as_i), .rw_i(rw_i), .addr_hi_i(addr_hi_i),
  .ad_io(ad_io), .addr_o(addr_o), .sel_o(sel_o), .rd_en_o(rd_en_o),
  .wr_en_o(wr_en_o), .ad_oe_o(ad_oe_o)
);

// File: tb/tb_mbus_decode.sv
module tb_mbus_decode;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        as_i = 1'b0;
  logic        rw_i = 1'b0;
  logic [7:0]  addr_hi_i = 8'h00;
  logic [39:0] rdata_i = '0;
  logic [7:0]  tb_ad = 8'h00;
  logic        tb_oe = 1'b0;
  wire  [7:0]  ad;
  logic [15:0] addr_o;
  logic [4:0]  sel_o, rd_en_o, wr_en_o;
  logic [7:0]  wdata_o;
  logic        ad_oe_o;

  int errors = 0;
  int checks = 0;

  assign ad = tb_oe ? tb_ad : 8'hzz;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_decode dut (
    .clk(clk), .rst(rst), .as_i(as_i), .rw_i(rw_i), .addr_hi_i(addr_hi_i),
    .ad_io(ad), .rdata_i(rdata_i), .addr_o(addr_o), .sel_o(sel_o),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o), .wdata_o(wdata_o), .ad_oe_o(ad_oe_o)
  );

  function automatic logic [4:0] exp_sel(logic [15:0] a);
    if (a == 16'h5000) return 5'b00001;
    if (a == 16'h5001) return 5'b00010;
    if (a >= 16'h4000 && a <= 16'h43FF) return 5'b00100;
    if (a <= 16'h4FFF) return 5'b01000;
    if (a >= 16'h2000 && a <= 16'h9FFF) return 5'b10000;
    return 5'b00000;
  endfunction

  function automatic string sel_req(logic [4:0] s);
    case (s)
      5'b00001, 5'b00010: return "R6";
      5'b00100: return "R3";
      5'b01000: return "R4";
      5'b10000: return "R5";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Put an address on the bus: strobe phase, then data phase.
  task automatic put_addr(logic [15:0] a, logic rw);
    @(negedge clk);
    addr_hi_i = a[15:8];
    as_i = 1'b1; tb_oe = 1'b1; tb_ad = a[7:0]; rw_i = rw;
    @(posedge clk); #1;
    chk("R9 strobe blocks drive", {31'b0, ad_oe_o}, 32'h0);
    @(negedge clk);
    as_i = 1'b0; tb_oe = 1'b0;
  endtask

  task automatic cycle(logic [15:0] a, logic rw);
    logic [4:0] es;
    logic [7:0] wv;
    logic [7:0] rb;
    rdata_i = {$urandom, $urandom};
    put_addr(a, rw);
    es = exp_sel(a);
    if (!rw) begin
      wv = 8'($urandom);
      tb_oe = 1'b1; tb_ad = wv;
    end
    #1;
    chk("R2 address", {16'h0, addr_o}, {16'h0, a});
    chk(sel_req(es), {27'h0, sel_o}, {27'h0, es});
    chk("R8 read enables", {27'h0, rd_en_o}, {27'h0, rw ? es : 5'b0});
    chk("R8 write enables", {27'h0, wr_en_o}, {27'h0, rw ? 5'b0 : es});
    chk("R9 drive enable", {31'h0, ad_oe_o}, {31'h0, rw && (es != 0)});
    if (rw && es != 0) begin
      rb = 8'h00;
      for (int k = 0; k < 5; k++) if (es[k]) rb = rdata_i[k*8 +: 8];
      chk("R9 read byte", {24'h0, ad}, {24'h0, rb});
    end
    if (!rw) chk("R10 write data", {24'h0, wdata_o}, {24'h0, wv});
    @(negedge clk);
    tb_oe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    addr_hi_i = 8'h50;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 reset clears low byte", {16'h0, addr_o}, 32'h5000);
    chk("R6 reset address selects input port", {27'h0, sel_o}, 32'h1);

    // R1: hold while strobe low even when pins change
    put_addr(16'h1234, 1'b0);
    held = addr_o;
    tb_oe = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tb_ad = 8'($urandom); @(negedge clk);
    end
    tb_oe = 1'b0;
    chk("R1 hold without strobe", {16'h0, addr_o}, {16'h0, held});
    // R1: reset after capture
    rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
    chk("R1 reset after capture", {24'h0, addr_o[7:0]}, 32'h0);

    // Directed edges
    cycle(16'h1FFF, 1'b1); cycle(16'h2000, 1'b1); cycle(16'h3FFF, 1'b0);
    cycle(16'h4000, 1'b1); cycle(16'h43FF, 1'b0); cycle(16'h4400, 1'b1);
    cycle(16'h4FFF, 1'b1); cycle(16'h5000, 1'b1); cycle(16'h5001, 1'b0);
    cycle(16'h5001, 1'b1); cycle(16'h5002, 1'b1); cycle(16'h9FFF, 1'b0);
    cycle(16'hA000, 1'b1); cycle(16'hFFFF, 1'b0); cycle(16'h0000, 1'b1);

    // Random traffic
    for (int i = 0; i < 400; i++) cycle(16'($urandom), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule